// File: doc/BRIEF.md
# PLL Fastlock Timeout Controller

This block sits beside a frequency synthesizer's loop logic and owns one of its control registers. Each programming word that arrives with the write strobe is checked against a fixed 4-bit control code. A matching word updates three settings: a timeout count, a fastlock charge-pump gain code and a cycle-slip-reduction rate code.

The timeout setting does two jobs. Small values (0 to 3) give the dual-purpose pin a static function: high impedance, a forced fastlock with the pin low, or a constant low or high drive. Larger values enable timed fastlock. Timed fastlock starts on the write, or later on a restart pulse, and lasts twice the programmed count in phase-detector comparison events. While fastlock is active the block presents the gain code and a valid slip-reduction code to the loop, and the pin drives low.

Registers update on the clock edge that samples the strobe. The outputs follow from registered state only, so they change one edge after the input that causes the change.

Top module: `fl_timeout_ctrl`

## Requirements
- R1: A write is accepted only when wr_data[3:0] equals 4'b1101. Any other value leaves every output and setting unchanged.
- R2: In an accepted word, wr_data[17:4] is the timeout value, wr_data[21:18] is the gain code and wr_data[23:22] is the slip-reduction code.
- R3: Timeout value 0: fastlock is off (fl_active=0, cp_code=0, csr_code=0) and pin_oe=0. Writing 0 during timed fastlock stops it on the next cycle.
- R4: Timeout value 1 (manual): fl_active=1 permanently, pin_oe=1, pin_do=0. Comparison events and restart pulses do not change this.
- R5: Timeout value 2 gives pin_oe=1 and pin_do=0. Timeout value 3 gives pin_oe=1 and pin_do=1. In both, fl_active=0.
- R6: A timeout value N >= 4 starts fastlock on the write. fl_active falls one cycle after the edge that samples the 2N-th comparison event, counted from cmp_evt high at rising edges. Further events have no effect.
- R7: A restart pulse in timed mode reloads the full 2N event count, including mid-run. In any other mode, restart has no effect.
- R8: In timed mode, pin_oe=1 and pin_do is 0 while fastlock is active and 1 otherwise.
- R9: cp_code equals the stored 4-bit gain code (gain = code+1) while fl_active=1, and 0 otherwise.
- R10: csr_code carries a stored slip-reduction code of 1 (rate 1/2) or 2 (rate 1/4) while fl_active=1. It is 0 when fastlock is inactive, and 0 for stored codes 0 and 3 (3 is reserved).
- R11: After synchronous active-low reset, all settings are zero: fl_active=0, pin_oe=0, pin_do=0, cp_code=0, csr_code=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 24 | Programming word: control code and fields |
| cmp_evt | input | 1 | One phase-detector comparison event per high cycle |
| restart | input | 1 | Restart timed fastlock |
| pin_do | output | 1 | Dual-purpose pin data |
| pin_oe | output | 1 | Dual-purpose pin output enable |
| fl_active | output | 1 | Fastlock active |
| cp_code | output | 4 | Fastlock charge-pump gain code |
| csr_code | output | 2 | Slip-reduction rate code, valid only during fastlock |

## Verification
The bench targets the duration boundary at both ends of the timeout range: value 4 (8 events) and value 16383 (32766 events), checking the last active event and the first inactive one. An off-by-one counter ends fastlock an event early or late, and a counter that drops the top bit wraps the long case.

It also covers:
- A restart in the middle of a run, which must reload rather than be ignored.
- Restarts and events in the static modes, which must not start anything.
- Reserved slip-reduction code 3, which must not leak to the output.
- A word with a wrong control code, which a decoder that ignores the low bits would accept and so change the pin.

// File: rtl/fl_pkg.sv
// Package: shared widths, control code and the pin-mode type for the
// fastlock timeout controller. Assumes a fixed 4-bit control field in the
// low bits of every programming word.
package fl_pkg;
    localparam int CTL_W     = 4;
    localparam int TOC_W     = 14;
    localparam int CPF_W     = 4;
    localparam int CSR_W     = 2;
    localparam logic [CTL_W-1:0] CTL_MATCH = 4'b1101;
    localparam int TIMED_MIN = 4;

    // Function of the dual-purpose pin, decided by the timeout value.
    typedef enum logic [2:0] {
        PM_HIZ    = 3'd0,
        PM_MANUAL = 3'd1,
        PM_LOW    = 3'd2,
        PM_HIGH   = 3'd3,
        PM_TIMED  = 3'd4
    } pin_mode_e;
endpackage

// File: rtl/fl_cfg_decode.sv
// fl_cfg_decode: recognizes writes for this register and holds the three
// fields. It also reports whether a write starts timed fastlock or stops it.
// Assumes wr_data is stable while wr_en is high; fields update on that edge.
module fl_cfg_decode
    import fl_pkg::*;
#(
    parameter int TOC_WIDTH = TOC_W,
    parameter int CPF_WIDTH = CPF_W,
    parameter int CSR_WIDTH = CSR_W,
    localparam int TOC_LO = CTL_W,
    localparam int CPF_LO = TOC_LO + TOC_WIDTH,
    localparam int CSR_LO = CPF_LO + CPF_WIDTH,
    localparam int WORD_W = CSR_LO + CSR_WIDTH
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [WORD_W-1:0]    wr_data,
    output logic [TOC_WIDTH-1:0] toc_q,
    output logic [CPF_WIDTH-1:0] cpf_q,
    output logic [CSR_WIDTH-1:0] csr_q,
    output pin_mode_e            mode,
    output logic                 wr_timed,
    output logic                 wr_static,
    output logic [TOC_WIDTH-1:0] wr_toc
);
    logic hit;

    // Match the control code and split out the incoming timeout field.
    always_comb begin
        hit       = wr_en && (wr_data[CTL_W-1:0] == CTL_MATCH);
        wr_toc    = wr_data[TOC_LO +: TOC_WIDTH];
        wr_timed  = hit && (wr_toc >= TOC_WIDTH'(TIMED_MIN));
        wr_static = hit && (wr_toc <  TOC_WIDTH'(TIMED_MIN));
    end

    // Field storage, loaded on an accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            toc_q <= '0;
            cpf_q <= '0;
            csr_q <= '0;
        end else if (hit) begin
            toc_q <= wr_toc;
            cpf_q <= wr_data[CPF_LO +: CPF_WIDTH];
            csr_q <= wr_data[CSR_LO +: CSR_WIDTH];
        end
    end

    // Classify the stored timeout value into a pin mode.
    always_comb begin
        case (toc_q)
            TOC_WIDTH'(0): mode = PM_HIZ;
            TOC_WIDTH'(1): mode = PM_MANUAL;
            TOC_WIDTH'(2): mode = PM_LOW;
            TOC_WIDTH'(3): mode = PM_HIGH;
            default:       mode = PM_TIMED;
        endcase
    end

    // R1: a word with a foreign control code changes no field.
    p_foreign_ignored_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[CTL_W-1:0] != CTL_MATCH) |=>
            $stable({toc_q, cpf_q, csr_q}));

    // R2: an accepted word lands its timeout field in storage.
    p_toc_captured_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[CTL_W-1:0] == CTL_MATCH) |=>
            toc_q == $past(wr_data[TOC_LO +: TOC_WIDTH]));
endmodule

// File: rtl/fl_event_timer.sv
// fl_event_timer: down-counter of comparison events for timed fastlock.
// It loads twice the timeout value on a timed write or on a gated restart,
// and counts down once per event. running is high while the count is nonzero.
// Priority: clear, then load, then restart, then count. Assumes restart_en is
// already qualified by timed mode.
module fl_event_timer #(
    parameter int TOC_WIDTH = 14,
    localparam int CNT_W = TOC_WIDTH + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 load,
    input  logic [TOC_WIDTH-1:0] load_val,
    input  logic                 restart_en,
    input  logic [TOC_WIDTH-1:0] reload_val,
    input  logic                 evt,
    output logic                 running
);
    logic [CNT_W-1:0] cnt_q;

    // Event counter with load, reload and clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clr)
            cnt_q <= '0;
        else if (load)
            cnt_q <= {load_val, 1'b0};
        else if (restart_en)
            cnt_q <= {reload_val, 1'b0};
        else if (evt && cnt_q != '0)
            cnt_q <= cnt_q - CNT_W'(1);
    end

    // Running flag, derived from the count.
    always_comb running = (cnt_q != '0);

    // R6: a load sets a count of twice the value (even, half equals value).
    p_load_double_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !clr) |=> ((cnt_q >> 1) == CNT_W'($past(load_val))) && !cnt_q[0]);

    // R6: each event while running removes exactly one from the count.
    p_step_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !load && !restart_en && evt && running) |=> cnt_q == $past(cnt_q) - CNT_W'(1));

    // R6: without events or control the count holds.
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !load && !restart_en && !evt) |=> $stable(cnt_q));

    // R7: a restart reloads twice the stored value.
    p_restart_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (restart_en && !load && !clr) |=> (cnt_q >> 1) == CNT_W'($past(reload_val)));
endmodule

// File: rtl/fl_out_stage.sv
// fl_out_stage: maps the pin mode and timer state onto the pin, the active
// flag and the loop control codes. Purely combinational; all inputs come
// from registers, so outputs change one edge after their cause.
module fl_out_stage
    import fl_pkg::*;
#(
    parameter int CPF_WIDTH = 4,
    parameter int CSR_WIDTH = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  pin_mode_e            mode,
    input  logic                 running,
    input  logic [CPF_WIDTH-1:0] cpf_q,
    input  logic [CSR_WIDTH-1:0] csr_q,
    output logic                 pin_do,
    output logic                 pin_oe,
    output logic                 fl_active,
    output logic [CPF_WIDTH-1:0] cp_code,
    output logic [CSR_WIDTH-1:0] csr_code
);
    logic csr_legal;

    // Pin function and active flag per mode.
    always_comb begin
        pin_do    = 1'b0;
        pin_oe    = 1'b1;
        fl_active = 1'b0;
        case (mode)
            PM_HIZ:    pin_oe = 1'b0;
            PM_MANUAL: fl_active = 1'b1;
            PM_LOW:    pin_do = 1'b0;
            PM_HIGH:   pin_do = 1'b1;
            PM_TIMED: begin
                fl_active = running;
                pin_do    = !running;
            end
            default:   pin_oe = 1'b0;
        endcase
    end

    // Only rate codes 1 and 2 are meaningful; 0 and reserved 3 disable.
    always_comb csr_legal = (csr_q == CSR_WIDTH'(1)) || (csr_q == CSR_WIDTH'(2));

    // Loop control codes, presented only during fastlock.
    always_comb begin
        cp_code  = fl_active ? cpf_q : '0;
        csr_code = (fl_active && csr_legal) ? csr_q : '0;
    end

    // R3: high-impedance mode never enables the pin or fastlock.
    p_hiz_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == PM_HIZ) |-> (!pin_oe && !fl_active && cp_code == '0));

    // R4: manual mode forces fastlock with the pin driven low.
    p_manual_forced_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == PM_MANUAL) |-> (fl_active && pin_oe && !pin_do));

    // R8: in timed mode the pin is the inverse of the active flag.
    p_pin_timed_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == PM_TIMED) |-> (pin_oe && (pin_do != fl_active)));

    // R10: the reserved code never reaches the output, nor any code when idle.
    p_csr_legal_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_code != 2'b11) && (fl_active || csr_code == '0));
endmodule

// File: rtl/fl_timeout_ctrl.sv
// fl_timeout_ctrl: top of the fastlock timeout controller. Decodes the
// control-register write, runs the comparison-event timer and drives the
// dual-purpose pin and the loop control codes. Synchronous active-low reset.
module fl_timeout_ctrl
    import fl_pkg::*;
#(
    parameter int TOC_WIDTH = TOC_W,
    parameter int CPF_WIDTH = CPF_W,
    parameter int CSR_WIDTH = CSR_W,
    localparam int WORD_W = CTL_W + TOC_WIDTH + CPF_WIDTH + CSR_WIDTH
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [WORD_W-1:0]    wr_data,
    input  logic                 cmp_evt,
    input  logic                 restart,
    output logic                 pin_do,
    output logic                 pin_oe,
    output logic                 fl_active,
    output logic [CPF_WIDTH-1:0] cp_code,
    output logic [CSR_WIDTH-1:0] csr_code
);
    logic [TOC_WIDTH-1:0] toc_q;
    logic [TOC_WIDTH-1:0] wr_toc;
    logic [CPF_WIDTH-1:0] cpf_q;
    logic [CSR_WIDTH-1:0] csr_q;
    pin_mode_e            mode;
    logic                 wr_timed;
    logic                 wr_static;
    logic                 restart_en;
    logic                 running;

    fl_cfg_decode #(
        .TOC_WIDTH(TOC_WIDTH),
        .CPF_WIDTH(CPF_WIDTH),
        .CSR_WIDTH(CSR_WIDTH)
    ) u_decode (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .toc_q     (toc_q),
        .cpf_q     (cpf_q),
        .csr_q     (csr_q),
        .mode      (mode),
        .wr_timed  (wr_timed),
        .wr_static (wr_static),
        .wr_toc    (wr_toc)
    );

    // Restart counts only when the stored setting is timed fastlock.
    always_comb restart_en = restart && (mode == PM_TIMED);

    fl_event_timer #(
        .TOC_WIDTH(TOC_WIDTH)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (wr_static),
        .load       (wr_timed),
        .load_val   (wr_toc),
        .restart_en (restart_en),
        .reload_val (toc_q),
        .evt        (cmp_evt),
        .running    (running)
    );

    fl_out_stage #(
        .CPF_WIDTH(CPF_WIDTH),
        .CSR_WIDTH(CSR_WIDTH)
    ) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode),
        .running   (running),
        .cpf_q     (cpf_q),
        .csr_q     (csr_q),
        .pin_do    (pin_do),
        .pin_oe    (pin_oe),
        .fl_active (fl_active),
        .cp_code   (cp_code),
        .csr_code  (csr_code)
    );

    // R6: a timed write always turns fastlock on at the next edge.
    p_timed_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_timed |=> fl_active);

    // R9: the gain code is visible exactly while fastlock is active.
    p_gain_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_active |-> (cp_code == '0));
endmodule

// File: tb/sim_fl_timeout_ctrl.sv
// Scoreboard bench: driver tasks push expected output sets, a monitor on the
// falling edge pops and compares them.
module sim_fl_timeout_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int WDOG_LIMIT = 200000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [23:0] wr_data = '0;
    logic        cmp_evt = 1'b0;
    logic        restart = 1'b0;
    logic        pin_do, pin_oe, fl_active;
    logic [3:0]  cp_code;
    logic [1:0]  csr_code;

    typedef struct packed {
        logic       d;
        logic       oe;
        logic       act;
        logic [3:0] cp;
        logic [1:0] csr;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    int    checks = 0;
    int    fails = 0;
    bit    done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fl_timeout_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .cmp_evt(cmp_evt), .restart(restart), .pin_do(pin_do), .pin_oe(pin_oe),
        .fl_active(fl_active), .cp_code(cp_code), .csr_code(csr_code)
    );

    task automatic expect_out(input string tag, input logic d, input logic oe,
                              input logic act, input logic [3:0] cp, input logic [1:0] csr);
        exp_q.push_back('{d: d, oe: oe, act: act, cp: cp, csr: csr});
        tag_q.push_back(tag);
    endtask

    task automatic write_word(input logic [1:0] csr, input logic [3:0] cpf,
                              input logic [13:0] toc, input logic [3:0] ctl);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = {csr, cpf, toc, ctl};
        @(posedge clk); #1;
        wr_en   = 1'b0;
    endtask

    task automatic events(input int n);
        @(negedge clk);
        cmp_evt = 1'b1;
        repeat (n) @(posedge clk);
        #1 cmp_evt = 1'b0;
    endtask

    task automatic pulse_restart();
        @(negedge clk);
        restart = 1'b1;
        @(posedge clk); #1;
        restart = 1'b0;
    endtask

    // Monitor: compare each pending expectation at the falling edge.
    always @(negedge clk) begin
        while (exp_q.size() > 0) begin
            exp_t  e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if ({pin_do, pin_oe, fl_active, cp_code, csr_code} !== e) begin
                fails++;
                $display("FAIL %s: got do=%b oe=%b act=%b cp=%0d csr=%0d, expected do=%b oe=%b act=%b cp=%0d csr=%0d",
                         t, pin_do, pin_oe, fl_active, cp_code, csr_code,
                         e.d, e.oe, e.act, e.cp, e.csr);
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        for (int i = 0; i < WDOG_LIMIT; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got running, expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        expect_out("R11 reset state", 0, 0, 0, 4'd0, 2'd0);

        // R3 high impedance, fields stored but unused
        write_word(2'd1, 4'd5, 14'd0, 4'b1101);
        expect_out("R3 hiz", 0, 0, 0, 4'd0, 2'd0);

        // R4 manual, R2 field placement, R9/R10 codes shown
        write_word(2'd2, 4'd7, 14'd1, 4'b1101);
        expect_out("R4 manual R2 fields", 0, 1, 1, 4'd7, 2'd2);
        events(3);
        pulse_restart();
        expect_out("R4 manual unaffected", 0, 1, 1, 4'd7, 2'd2);

        // R5 constant drives
        write_word(2'd1, 4'd3, 14'd2, 4'b1101);
        expect_out("R5 const low", 0, 1, 0, 4'd0, 2'd0);
        pulse_restart();
        expect_out("R7 restart ignored static", 0, 1, 0, 4'd0, 2'd0);
        write_word(2'd1, 4'd3, 14'd3, 4'b1101);
        expect_out("R5 const high", 1, 1, 0, 4'd0, 2'd0);

        // R1 foreign control code ignored
        write_word(2'd0, 4'd0, 14'd0, 4'b1100);
        expect_out("R1 foreign word", 1, 1, 0, 4'd0, 2'd0);

        // R6 smallest timed value, R10 reserved code
        write_word(2'd3, 4'd9, 14'd4, 4'b1101);
        expect_out("R10 reserved csr", 0, 1, 1, 4'd9, 2'd0);
        events(7);
        expect_out("R6 active after 7 of 8", 0, 1, 1, 4'd9, 2'd0);
        events(1);
        expect_out("R6 R8 done after 8", 1, 1, 0, 4'd0, 2'd0);
        events(2);
        expect_out("R6 extra events", 1, 1, 0, 4'd0, 2'd0);

        // R7 restart after completion and mid-run
        pulse_restart();
        expect_out("R7 restart", 0, 1, 1, 4'd9, 2'd0);
        events(5);
        pulse_restart();
        events(7);
        expect_out("R7 midrun reload", 0, 1, 1, 4'd9, 2'd0);
        events(1);
        expect_out("R7 reload ends", 1, 1, 0, 4'd0, 2'd0);

        // R10 rate code 1 passes, R9 max gain
        write_word(2'd1, 4'd15, 14'd5, 4'b1101);
        expect_out("R10 csr1 R9 gain", 0, 1, 1, 4'd15, 2'd1);
        events(9);
        expect_out("R6 active after 9 of 10", 0, 1, 1, 4'd15, 2'd1);
        events(1);
        expect_out("R10 gated when idle", 1, 1, 0, 4'd0, 2'd0);

        // R3 writing 0 stops running fastlock
        write_word(2'd2, 4'd4, 14'd4, 4'b1101);
        events(2);
        write_word(2'd2, 4'd4, 14'd0, 4'b1101);
        expect_out("R3 stop midrun", 0, 0, 0, 4'd0, 2'd0);
        pulse_restart();
        expect_out("R7 restart ignored hiz", 0, 0, 0, 4'd0, 2'd0);

        // R6 largest value
        write_word(2'd2, 4'd1, 14'd16383, 4'b1101);
        events(32765);
        expect_out("R6 active after 32765", 0, 1, 1, 4'd1, 2'd2);
        events(1);
        expect_out("R6 done after 32766", 1, 1, 0, 4'd0, 2'd0);

        // R11 reset clears settings
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk); #1;
        rst_n = 1'b1;
        expect_out("R11 after reset", 0, 0, 0, 4'd0, 2'd0);

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule